// File: doc/BRIEF.md
# STOP standby sequencer

This block sequences a small microcontroller into and out of its deepest clock-stopped standby state. The CPU signals a STOP instruction with a one-cycle request pulse. The block accepts it only while the CPU runs from the high-speed system clock or the internal ring oscillator. On entry it switches off the high-speed oscillator and gates the CPU clock. Every other clock stays untouched, and port latches keep their values because the CPU never clocks them.

An interrupt source releases standby when its request flag is set and its mask flag is clear. If such a source is already pending when STOP is requested, the oscillator is never switched off. The block drops into a HALT-like hold instead. Either way the CPU clock stays gated through a programmable stabilization wait. The wait is counted on a free-running clock that keeps running in standby. After the wait the block raises a one-cycle resume pulse and ungates the CPU.

A static configuration input decides whether software may stop the ring oscillator or whether it is locked on. Entering standby never changes the ring oscillator.

Top module: `stop_sequencer`

## Requirements
- R1: After reset the block is in RUN with hs_osc_en_o=1, cpu_clk_en_o=1 and resume_o=0.
- R2: A stop_req_i pulse in RUN with clk_src_i=0 (high-speed) or clk_src_i=1 (ring) and no pending wake gives hs_osc_en_o=0 and cpu_clk_en_o=0 from the next cycle.
- R3: A stop_req_i pulse with clk_src_i=2 (subsystem) or clk_src_i=3 (unused code) is ignored: cpu_clk_en_o and hs_osc_en_o stay 1 and no resume pulse follows.
- R4: Bit i of irq_flag_i wakes the block only when bit i of irq_mask_i is 0 (a mask of 1 blocks the source). Masked requests leave the block stopped.
- R5: Waking from STOP turns hs_osc_en_o on in the cycle after the wake is sampled, while cpu_clk_en_o stays 0. resume_o and cpu_clk_en_o rise at the (N+1)-th edge, counting the edge that samples the wake as the first.
- R6: A STOP request made while a wake is pending keeps hs_osc_en_o=1 and gates the CPU. resume_o rises at the (N+2)-th edge, counting the request-sampling edge as the first.
- R7: The wait N is set by osc_wait_sel_i as sampled when the wait starts. Codes 0, 1, 2, 3 and 4 give N = 2^B, 2^(B+2), 2^(B+3), 2^(B+4) and 2^(B+5). Codes 5 to 7 give 2^(B+5). B is parameter BASE_LOG2, default 11.
- R8: resume_o is high for exactly one cycle, which is also the first cycle of cpu_clk_en_o=1.
- R9: ring_en_o is 1 whenever ring_lock_i=1. Otherwise ring_en_o equals the inverse of ring_sw_off_i. STOP state never changes it.
- R10: stop_req_i is ignored outside RUN. A pulse during the stabilization wait neither lengthens nor ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock, present during standby |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_req_i | input | 1 | One-cycle STOP instruction pulse |
| clk_src_i | input | 2 | Current CPU clock source: 0 high-speed, 1 ring, 2 subsystem |
| irq_flag_i | input | N_IRQ | Interrupt request flags |
| irq_mask_i | input | N_IRQ | Interrupt mask flags, 1 = masked |
| osc_wait_sel_i | input | 3 | Stabilization wait select |
| ring_lock_i | input | 1 | Static config: 1 = ring oscillator cannot be stopped |
| ring_sw_off_i | input | 1 | Software request to stop the ring oscillator |
| hs_osc_en_o | output | 1 | High-speed oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| ring_en_o | output | 1 | Ring oscillator enable |
| resume_o | output | 1 | One-cycle CPU resume pulse |

## Verification
The assertions take three things for granted. First, stop_req_i is a single-cycle pulse. Second, clk_i keeps running in standby. Third, osc_wait_sel_i holds steady from the moment a wait starts. The checks tied to a request and the following cycle also assume the request-time view of irq_flag_i and irq_mask_i is the one the block acts on. The stimulus changes the wait select, source, flags and masks only on falling edges while the block is in RUN. The one exception is the wake flag, which is raised while the block is stopped. Every STOP request is a single-cycle pulse.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_HALT = 2'd2,
    ST_STAB = 2'd3
  } sseq_state_e;

  typedef enum logic [1:0] {
    SRC_HS   = 2'd0,
    SRC_RING = 2'd1,
    SRC_SUB  = 2'd2,
    SRC_RSVD = 2'd3
  } clk_src_e;

  // log2 of the stabilization wait for a select code
  function automatic int unsigned wait_log2(input logic [SEL_W-1:0] sel,
                                            input int unsigned base);
    case (sel)
      3'd0:    return base;
      3'd1:    return base + 2;
      3'd2:    return base + 3;
      3'd3:    return base + 4;
      default: return base + 5;
    endcase
  endfunction

endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_mask_i,
  output logic             wake_o
);

  logic [N_IRQ-1:0] live;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign live[i] = irq_flag_i[i] & ~irq_mask_i[i];
  end

  assign wake_o = |live;

endmodule

// File: rtl/stab_timer.sv
module stab_timer
  import stop_seq_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 11,
  localparam int unsigned CNT_W = BASE_LOG2 + 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= (ONE << wait_log2(sel_i, BASE_LOG2)) - ONE;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - ONE;
    end
  end

  assign done_o = active_q && (cnt_q == '0);

  assert_no_early_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_o);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> !done_o);

endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
  import stop_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stop_req_i,
  input  logic [1:0]  clk_src_i,
  input  logic        wake_i,
  input  logic        timer_done_i,
  output logic        timer_load_o,
  output logic        hs_osc_en_o,
  output logic        cpu_clk_en_o,
  output logic        resume_o
);

  sseq_state_e state_q, state_d;
  logic        src_ok;

  assign src_ok = (clk_src_i == SRC_HS) || (clk_src_i == SRC_RING);

  always_comb begin
    state_d      = state_q;
    timer_load_o = 1'b0;
    unique case (state_q)
      ST_RUN:  if (stop_req_i && src_ok) state_d = wake_i ? ST_HALT : ST_STOP;
      ST_STOP: if (wake_i) begin
                 state_d      = ST_STAB;
                 timer_load_o = 1'b1;
               end
      ST_HALT: begin
                 state_d      = ST_STAB;
                 timer_load_o = 1'b1;
               end
      ST_STAB: if (timer_done_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  // outputs registered from next state: glitch-free enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RUN;
      hs_osc_en_o  <= 1'b1;
      cpu_clk_en_o <= 1'b1;
      resume_o     <= 1'b0;
    end else begin
      state_q      <= state_d;
      hs_osc_en_o  <= (state_d != ST_STOP);
      cpu_clk_en_o <= (state_d == ST_RUN);
      resume_o     <= (state_q == ST_STAB) && (state_d == ST_RUN);
    end
  end

  assert_enter_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_req_i && src_ok && !wake_i) |=> (!hs_osc_en_o && !cpu_clk_en_o));

  assert_ignore_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_req_i && (clk_src_i == SRC_SUB || clk_src_i == SRC_RSVD))
      |=> (cpu_clk_en_o && hs_osc_en_o));

  assert_stop_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && !wake_i) |=> !hs_osc_en_o);

  assert_wake_osc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && wake_i) |=> (hs_osc_en_o && !cpu_clk_en_o));

  assert_fallback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_req_i && src_ok && wake_i) |=> (hs_osc_en_o && !cpu_clk_en_o));

  assert_resume_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  assert_resume_clk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> resume_o);

  assert_busy_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAB && !timer_done_i) |=> !cpu_clk_en_o);

endmodule

// File: rtl/stop_sequencer.sv
module stop_sequencer
  import stop_seq_pkg::*;
#(
  parameter int unsigned N_IRQ     = 8,
  parameter int unsigned BASE_LOG2 = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic [1:0]       clk_src_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_mask_i,
  input  logic [2:0]       osc_wait_sel_i,
  input  logic             ring_lock_i,
  input  logic             ring_sw_off_i,
  output logic             hs_osc_en_o,
  output logic             cpu_clk_en_o,
  output logic             ring_en_o,
  output logic             resume_o
);

  logic wake;
  logic timer_load;
  logic timer_done;

  wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_flag_i (irq_flag_i),
    .irq_mask_i (irq_mask_i),
    .wake_o     (wake)
  );

  stab_timer #(.BASE_LOG2(BASE_LOG2)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (timer_load),
    .sel_i  (osc_wait_sel_i),
    .done_o (timer_done)
  );

  stop_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_req_i   (stop_req_i),
    .clk_src_i    (clk_src_i),
    .wake_i       (wake),
    .timer_done_i (timer_done),
    .timer_load_o (timer_load),
    .hs_osc_en_o  (hs_osc_en_o),
    .cpu_clk_en_o (cpu_clk_en_o),
    .resume_o     (resume_o)
  );

  // ring oscillator: standby never touches it, only the lock/software pair
  assign ring_en_o = ring_lock_i | ~ring_sw_off_i;

  assert_ring_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_lock_i |-> ring_en_o);

endmodule

// File: tb/stop_sequencer_tb.sv
`timescale 1ns/1ps
module stop_sequencer_tb;

  localparam int unsigned N_IRQ = 8;
  localparam int unsigned B     = 4;

  typedef struct packed {
    logic [2:0] sel;
    logic [1:0] src;
    logic [7:0] flg;
    logic [7:0] msk;
    logic [1:0] kind;   // 0 ignored, 1 stop, 2 halt fallback
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 8'h00, 8'h00, 2'd1},
    '{3'd1, 2'd1, 8'h00, 8'h00, 2'd1},
    '{3'd2, 2'd0, 8'h04, 8'h04, 2'd1},
    '{3'd3, 2'd1, 8'h01, 8'h00, 2'd2},
    '{3'd4, 2'd0, 8'h80, 8'h7f, 2'd2},
    '{3'd5, 2'd0, 8'h00, 8'h00, 2'd1},
    '{3'd7, 2'd1, 8'h10, 8'h00, 2'd2},
    '{3'd0, 2'd2, 8'h00, 8'h00, 2'd0},
    '{3'd0, 2'd3, 8'h00, 8'h00, 2'd0},
    '{3'd6, 2'd2, 8'h01, 8'h00, 2'd0},
    '{3'd2, 2'd0, 8'hff, 8'hff, 2'd1}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             stop_req_i = 1'b0;
  logic [1:0]       clk_src_i = 2'd0;
  logic [N_IRQ-1:0] irq_flag_i = '0;
  logic [N_IRQ-1:0] irq_mask_i = '0;
  logic [2:0]       osc_wait_sel_i = 3'd0;
  logic             ring_lock_i = 1'b0;
  logic             ring_sw_off_i = 1'b0;
  logic             hs_osc_en_o, cpu_clk_en_o, ring_en_o, resume_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  stop_sequencer #(.N_IRQ(N_IRQ), .BASE_LOG2(B)) u_dut (
    .clk_i, .rst_ni, .stop_req_i, .clk_src_i, .irq_flag_i, .irq_mask_i,
    .osc_wait_sel_i, .ring_lock_i, .ring_sw_off_i,
    .hs_osc_en_o, .cpu_clk_en_o, .ring_en_o, .resume_o
  );

  function automatic int wait_n(input logic [2:0] s);
    case (s)
      3'd0:    return 1 << B;
      3'd1:    return 1 << (B + 2);
      3'd2:    return 1 << (B + 3);
      3'd3:    return 1 << (B + 4);
      default: return 1 << (B + 5);
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count falling edges until resume_o is seen, starting from k0
  task automatic wait_resume(input int k0, output int k);
    k = k0;
    do begin
      @(negedge clk_i);
      k++;
    end while (!resume_o && k < 4000);
  endtask

  task automatic pulse_stop();
    @(negedge clk_i);
    stop_req_i = 1'b1;
    @(negedge clk_i);
    stop_req_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    vec_t v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 hs_osc_en", int'(hs_osc_en_o), 1);
    chk("R1 cpu_clk_en", int'(cpu_clk_en_o), 1);
    chk("R1 resume", int'(resume_o), 0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      @(negedge clk_i);
      osc_wait_sel_i = v.sel;
      clk_src_i      = v.src;
      irq_flag_i     = v.flg;
      irq_mask_i     = v.msk;
      pulse_stop();
      case (v.kind)
        2'd0: begin
          chk("R3 cpu_clk_en after ignored stop", int'(cpu_clk_en_o), 1);
          chk("R3 hs_osc_en after ignored stop", int'(hs_osc_en_o), 1);
          repeat (3) @(negedge clk_i);
          chk("R3 no resume", int'(resume_o), 0);
          chk("R3 cpu_clk_en held", int'(cpu_clk_en_o), 1);
        end
        2'd1: begin
          chk("R2 hs_osc_en off", int'(hs_osc_en_o), 0);
          chk("R2 cpu_clk_en off", int'(cpu_clk_en_o), 0);
          repeat (4) @(negedge clk_i);
          chk("R4 masked flags keep stop", int'(hs_osc_en_o), 0);
          irq_flag_i = v.flg | 8'h08;
          irq_mask_i = v.msk & ~8'h08;
          @(negedge clk_i);
          chk("R5 hs_osc_en on after wake", int'(hs_osc_en_o), 1);
          chk("R5 cpu gated in wait", int'(cpu_clk_en_o), 0);
          wait_resume(1, k);
          chk("R7 wait length from stop", k, wait_n(v.sel) + 1);
          chk("R8 cpu_clk_en with resume", int'(cpu_clk_en_o), 1);
          @(negedge clk_i);
          chk("R8 resume one cycle", int'(resume_o), 0);
        end
        default: begin
          chk("R6 hs_osc_en kept", int'(hs_osc_en_o), 1);
          chk("R6 cpu gated", int'(cpu_clk_en_o), 0);
          wait_resume(1, k);
          chk("R6 wait length from halt", k, wait_n(v.sel) + 2);
          @(negedge clk_i);
          chk("R8 resume one cycle", int'(resume_o), 0);
        end
      endcase
      irq_flag_i = '0;
      irq_mask_i = '0;
    end

    // R10: stop request during the wait is ignored
    osc_wait_sel_i = 3'd0;
    clk_src_i      = 2'd0;
    pulse_stop();
    irq_flag_i = 8'h02;
    @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    stop_req_i = 1'b1;
    @(negedge clk_i);
    stop_req_i = 1'b0;
    chk("R10 cpu still gated", int'(cpu_clk_en_o), 0);
    wait_resume(5, k);
    chk("R10 wait unchanged", k, wait_n(3'd0) + 1);
    irq_flag_i = '0;
    @(negedge clk_i);

    // R9: ring oscillator control
    ring_lock_i = 1'b0; ring_sw_off_i = 1'b1;
    #1 chk("R9 stoppable, sw off", int'(ring_en_o), 0);
    ring_lock_i = 1'b1;
    #1 chk("R9 locked ignores sw off", int'(ring_en_o), 1);
    ring_lock_i = 1'b0; ring_sw_off_i = 1'b0;
    pulse_stop();
    chk("R9 ring on through stop", int'(ring_en_o), 1);

    // R1: reset while stopped
    rst_ni = 1'b0;
    #1;
    chk("R1 reset in stop hs_osc_en", int'(hs_osc_en_o), 1);
    chk("R1 reset in stop cpu_clk_en", int'(cpu_clk_en_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 run after reset", int'(cpu_clk_en_o), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule